// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Core

This block is the scheduling core of an out-of-order floating-point datapath. Operations arrive one at a time from an in-order operation queue and are placed into a free reservation station of the matching class: adder stations for add and subtract, multiplier stations, load buffers and store buffers. At issue, each source register is read from a register status table. If no unit is still going to write that register, the value is copied into the station. If a write is still outstanding, the station records the tag of the producing station instead. This renames the architectural registers implicitly, so later writers of a register never stall earlier readers or earlier writers.

Finished results leave over a single shared result bus that carries the data together with the tag of the station that produced it. Every waiting station, store buffer and register status entry compares its pending tag against the bus tag and captures the value in the same cycle. A station starts its fixed-latency execution stub only once both operands are present. It releases itself in the cycle its result is granted the bus. Loads are latency-only models: the loaded value travels with the operation, and a hit flag selects the short or the long latency. Stores wait for their data operand and then leave through a dedicated store port.

Top module: `tr_core`

## Requirements
- R1: `iss_ready` is low whenever no station of the class the presented opcode needs is free. There are 3 adder, 2 multiplier, 6 load and 3 store entries. An operation presented while `iss_ready` is low is not taken.
- R2: The opcodes are 0 add, 1 subtract, 2 multiply (low 64 bits), 3 load and 4 store. The result of an arithmetic operation is computed from the source values held at issue. For a load, the result is `iss_imm`.
- R3: The result bus presents `cdb_valid`, a 4-bit tag and 64 data bits. Tags are 1..3 for the adders, 4..5 for the multipliers and 6..11 for the loads, and the lowest-numbered free station of a class is chosen. A valid bus never carries tag 0.
- R4: In the cycle a tag is on the bus, every station operand, store buffer and register status entry waiting on that tag captures the data. An operation issued in that same cycle also takes the value from the bus rather than the tag.
- R5: A station executes only when both operands are present. With operands ready at issue, the result appears on the bus LAT+1 cycles after the issue edge: LAT is 2 for add and subtract, 4 for multiply, 1 for a load hit and 8 for a load miss. An operand delivered by the bus adds two cycles after that broadcast.
- R6: A station is freed by the bus grant of its result and can be reused afterwards. Each issued operation broadcasts exactly once, and the same tag never appears on two consecutive bus cycles.
- R7: The register status entry always holds the tag of the newest issued writer. A broadcast updates a register only when that register's status still equals the broadcast tag, so an older writer finishing late leaves the newer value in place.
- R8: At most one result uses the bus per cycle. When several are done, the lowest tag wins, and each losing unit keeps presenting the same tag and data until it is granted.
- R9: A store takes its data from `iss_src1` and its address from the low 16 bits of `iss_imm`. It raises `st_valid` with that address and data in the first cycle in which its data is present: this is the cycle right after issue when the data is ready, otherwise the cycle after the capturing broadcast.
- R10: After a synchronous active-low reset all stations are free, `iss_ready` is high for every valid opcode, `cdb_valid` and `st_valid` are low, and every register reads zero with no pending tag.
- R11: A reader that captured a value at issue is not affected by a later writer of the same register issued before the reader executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation is presented for issue |
| iss_op | input | 3 | Opcode (0 add, 1 sub, 2 mul, 3 load, 4 store) |
| iss_dst | input | 4 | Destination register (unused by store) |
| iss_src1 | input | 4 | First source register; store data register |
| iss_src2 | input | 4 | Second source register |
| iss_imm | input | 64 | Load value or store address |
| iss_hit | input | 1 | Load latency select: 1 hit, 0 miss |
| iss_ready | output | 1 | A station of the required class is free |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 4 | Producing station tag |
| cdb_data | output | 64 | Result value |
| st_valid | output | 1 | A store completes this cycle |
| st_addr | output | 16 | Store address |
| st_data | output | 64 | Store data |

## Verification
The assertions check the bus rules on every cycle: at most one grant, a nonzero tag in range, no tag repeated back to back, and losers that keep their tag and data steady. They also check that the register status takes the newest writer's tag and clears on a matching broadcast. The directed scenarios show what needs whole instruction sequences: exact latencies, operand forwarding in the issue cycle, dependent operations waiting on a load miss, and stores completing on captured data. They also cover the write-after-write and write-after-read cases, a full multiplier class stalling issue, and an add and a multiply colliding on the bus.

// File: rtl/tr_pkg.sv
// Shared types for the tag-renaming reservation station core.
package tr_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_EXEC,
        ST_DONE
    } st_e;

endpackage

// File: rtl/tr_station_unit.sv
// Bank of N reservation stations of one class with a fixed-latency stub.
// Each station holds two operands (value or pending tag), snoops the result
// bus, counts down its latency once both operands are present and then
// requests the bus. Assumes alloc only when has_free is high, and alloc_lat >= 1.
module tr_station_unit
    import tr_pkg::*;
#(
    parameter int N        = 3,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 64,
    parameter int LAT_W    = 4,
    parameter int BASE_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  op_e               alloc_op,
    input  logic [DATA_W-1:0] alloc_vj,
    input  logic [DATA_W-1:0] alloc_vk,
    input  logic [TAG_W-1:0]  alloc_qj,
    input  logic [TAG_W-1:0]  alloc_qk,
    input  logic [LAT_W-1:0]  alloc_lat,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              has_free,
    output logic [TAG_W-1:0]  free_tag,
    output logic              req,
    output logic [TAG_W-1:0]  req_tag,
    output logic [DATA_W-1:0] req_data,
    input  logic              grant
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    st_e               state [N];
    op_e               op    [N];
    logic [DATA_W-1:0] vj    [N];
    logic [DATA_W-1:0] vk    [N];
    logic [DATA_W-1:0] res   [N];
    logic [TAG_W-1:0]  qj    [N];
    logic [TAG_W-1:0]  qk    [N];
    logic [LAT_W-1:0]  cnt   [N];

    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  done_idx;

    // Stub arithmetic of the execution unit.
    function automatic logic [DATA_W-1:0] calc(input op_e o,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
        case (o)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return a * b;
            default: return a;
        endcase
    endfunction

    // Lowest free station and lowest finished station.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        req      = 1'b0;
        done_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (state[i] == ST_IDLE) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (state[i] == ST_DONE) begin
                req      = 1'b1;
                done_idx = IDX_W'(i);
            end
        end
    end

    assign free_tag = TAG_W'(BASE_TAG) + TAG_W'(free_idx);
    assign req_tag  = TAG_W'(BASE_TAG) + TAG_W'(done_idx);
    assign req_data = res[done_idx];

    // Station life cycle: allocate, snoop, execute, broadcast, free.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                state[i] <= ST_IDLE;
                op[i]    <= OP_ADD;
                vj[i]    <= '0;
                vk[i]    <= '0;
                res[i]   <= '0;
                qj[i]    <= '0;
                qk[i]    <= '0;
                cnt[i]   <= '0;
            end else if (alloc && free_idx == IDX_W'(i)) begin
                state[i] <= ST_WAIT;
                op[i]    <= alloc_op;
                vj[i]    <= alloc_vj;
                vk[i]    <= alloc_vk;
                qj[i]    <= alloc_qj;
                qk[i]    <= alloc_qk;
                cnt[i]   <= alloc_lat;
            end else begin
                case (state[i])
                    ST_WAIT: begin
                        if (bus_valid && qj[i] != '0 && qj[i] == bus_tag) begin
                            vj[i] <= bus_data;
                            qj[i] <= '0;
                        end
                        if (bus_valid && qk[i] != '0 && qk[i] == bus_tag) begin
                            vk[i] <= bus_data;
                            qk[i] <= '0;
                        end
                        if (qj[i] == '0 && qk[i] == '0) begin
                            state[i] <= ST_EXEC;
                            cnt[i]   <= cnt[i] - 1'b1;
                        end
                    end
                    ST_EXEC: begin
                        if (cnt[i] == '0) begin
                            res[i]   <= calc(op[i], vj[i], vk[i]);
                            state[i] <= ST_DONE;
                        end else begin
                            cnt[i] <= cnt[i] - 1'b1;
                        end
                    end
                    ST_DONE: begin
                        if (grant && done_idx == IDX_W'(i)) state[i] <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tr_store_buf.sv
// Store buffers: each holds an address and a data operand that is either a
// value or a pending tag captured from the result bus. An entry with its data
// present completes through the store port (lowest index first) and frees.
// Assumes alloc only when has_free is high.
module tr_store_buf #(
    parameter int N      = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_v,
    input  logic [TAG_W-1:0]  alloc_q,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              has_free,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic              busy [N];
    logic [TAG_W-1:0]  q    [N];
    logic [DATA_W-1:0] v    [N];
    logic [ADDR_W-1:0] addr [N];
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  out_idx;

    // Lowest free entry and lowest entry ready to complete.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        st_valid = 1'b0;
        out_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (busy[i] && q[i] == '0) begin
                st_valid = 1'b1;
                out_idx  = IDX_W'(i);
            end
        end
    end

    assign st_addr = addr[out_idx];
    assign st_data = v[out_idx];

    // Entry allocation, data snooping and retirement.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                busy[i] <= 1'b0;
                q[i]    <= '0;
                v[i]    <= '0;
                addr[i] <= '0;
            end else if (alloc && free_idx == IDX_W'(i)) begin
                busy[i] <= 1'b1;
                q[i]    <= alloc_q;
                v[i]    <= alloc_v;
                addr[i] <= alloc_addr;
            end else if (busy[i]) begin
                if (st_valid && out_idx == IDX_W'(i)) begin
                    busy[i] <= 1'b0;
                end else if (bus_valid && q[i] != '0 && q[i] == bus_tag) begin
                    v[i] <= bus_data;
                    q[i] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/tr_bus_arb.sv
// Fixed-priority result bus arbiter: requester 0 has the highest priority.
// Units are ordered by ascending tag range, so the lowest tag wins.
module tr_bus_arb #(
    parameter int NU     = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic [NU-1:0]             req,
    input  logic [NU-1:0][TAG_W-1:0]  req_tag,
    input  logic [NU-1:0][DATA_W-1:0] req_data,
    output logic [NU-1:0]             gnt,
    output logic                      bus_valid,
    output logic [TAG_W-1:0]          bus_tag,
    output logic [DATA_W-1:0]         bus_data
);

    // Pick the lowest-index requester.
    always_comb begin
        gnt       = '0;
        bus_valid = 1'b0;
        bus_tag   = '0;
        bus_data  = '0;
        for (int u = NU - 1; u >= 0; u--) begin
            if (req[u]) begin
                gnt       = '0;
                gnt[u]    = 1'b1;
                bus_valid = 1'b1;
                bus_tag   = req_tag[u];
                bus_data  = req_data[u];
            end
        end
    end

endmodule

// File: rtl/tr_core.sv
// Reservation station core: issue from an in-order queue into adder,
// multiplier, load and store stations, implicit renaming through a register
// status table, and a single tagged result bus. Assumes one operation offered
// per cycle; the tag space must hold all adder, multiplier and load stations.
module tr_core
    import tr_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter int TAG_W       = 4,
    parameter int ADDR_W      = 16,
    parameter int NREG        = 16,
    parameter int N_ADD       = 3,
    parameter int N_MUL       = 2,
    parameter int N_LD        = 6,
    parameter int N_ST        = 3,
    parameter int ADD_LAT     = 2,
    parameter int MUL_LAT     = 4,
    parameter int LD_HIT_LAT  = 1,
    parameter int LD_MISS_LAT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [2:0]              iss_op,
    input  logic [$clog2(NREG)-1:0] iss_dst,
    input  logic [$clog2(NREG)-1:0] iss_src1,
    input  logic [$clog2(NREG)-1:0] iss_src2,
    input  logic [DATA_W-1:0]       iss_imm,
    input  logic                    iss_hit,
    output logic                    iss_ready,
    output logic                    cdb_valid,
    output logic [TAG_W-1:0]        cdb_tag,
    output logic [DATA_W-1:0]       cdb_data,
    output logic                    st_valid,
    output logic [ADDR_W-1:0]       st_addr,
    output logic [DATA_W-1:0]       st_data
);

    localparam int REG_W    = $clog2(NREG);
    localparam int ADD_BASE = 1;
    localparam int MUL_BASE = ADD_BASE + N_ADD;
    localparam int LD_BASE  = MUL_BASE + N_MUL;
    localparam int NTAG     = LD_BASE + N_LD - 1;
    localparam int MAX_A    = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int MAX_B    = (LD_HIT_LAT > LD_MISS_LAT) ? LD_HIT_LAT : LD_MISS_LAT;
    localparam int MAX_LAT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int LAT_W    = $clog2(MAX_LAT + 1);
    localparam int NU       = 3;

    op_e                          op;
    logic                         sel_add, sel_mul, sel_ld, sel_st;
    logic                         iss_fire, iss_writes;
    logic [TAG_W-1:0]             iss_tag;
    logic [LAT_W-1:0]             iss_lat;
    logic [DATA_W-1:0]            s1_v, s2_v, pay_vj;
    logic [TAG_W-1:0]             s1_q, s2_q, pay_qj, pay_qk;

    logic [NREG-1:0][TAG_W-1:0]   reg_tag;
    logic [DATA_W-1:0]            reg_val [NREG];

    logic                         add_free, mul_free, ld_free, st_free;
    logic [TAG_W-1:0]             add_tag, mul_tag, ld_tag;
    logic [NU-1:0]                unit_req, unit_gnt;
    logic [NU-1:0][TAG_W-1:0]     unit_rtag;
    logic [NU-1:0][DATA_W-1:0]    unit_rdata;

    // Opcode decode into station class.
    always_comb begin
        op      = op_e'(iss_op);
        sel_add = (op == OP_ADD) || (op == OP_SUB);
        sel_mul = (op == OP_MUL);
        sel_ld  = (op == OP_LOAD);
        sel_st  = (op == OP_STORE);
    end

    // Structural hazard check and issue strobe.
    always_comb begin
        iss_ready = (sel_add && add_free) || (sel_mul && mul_free) ||
                    (sel_ld && ld_free) || (sel_st && st_free);
        iss_fire   = iss_valid && iss_ready;
        iss_writes = iss_fire && !sel_st;
        iss_tag    = sel_add ? add_tag : (sel_mul ? mul_tag : ld_tag);
    end

    // Per-class latency of the execution stub.
    always_comb begin
        case (op)
            OP_MUL:  iss_lat = LAT_W'(MUL_LAT);
            OP_LOAD: iss_lat = iss_hit ? LAT_W'(LD_HIT_LAT) : LAT_W'(LD_MISS_LAT);
            default: iss_lat = LAT_W'(ADD_LAT);
        endcase
    end

    // Source reads with same-cycle forwarding from the result bus.
    always_comb begin
        if (reg_tag[iss_src1] == '0) begin
            s1_v = reg_val[iss_src1];
            s1_q = '0;
        end else if (cdb_valid && cdb_tag == reg_tag[iss_src1]) begin
            s1_v = cdb_data;
            s1_q = '0;
        end else begin
            s1_v = '0;
            s1_q = reg_tag[iss_src1];
        end
        if (reg_tag[iss_src2] == '0) begin
            s2_v = reg_val[iss_src2];
            s2_q = '0;
        end else if (cdb_valid && cdb_tag == reg_tag[iss_src2]) begin
            s2_v = cdb_data;
            s2_q = '0;
        end else begin
            s2_v = '0;
            s2_q = reg_tag[iss_src2];
        end
        pay_vj = sel_ld ? iss_imm : s1_v;
        pay_qj = sel_ld ? '0 : s1_q;
        pay_qk = sel_ld ? '0 : s2_q;
    end

    // Register status and value update: newest writer wins, matching tag clears.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                reg_tag[r] <= '0;
                reg_val[r] <= '0;
            end else begin
                if (cdb_valid && reg_tag[r] != '0 && reg_tag[r] == cdb_tag) begin
                    reg_val[r] <= cdb_data;
                    reg_tag[r] <= '0;
                end
                if (iss_writes && iss_dst == REG_W'(r)) reg_tag[r] <= iss_tag;
            end
        end
    end

    tr_station_unit #(.N(N_ADD), .TAG_W(TAG_W), .DATA_W(DATA_W), .LAT_W(LAT_W),
                      .BASE_TAG(ADD_BASE)) u_add (
        .clk(clk), .rst_n(rst_n),
        .alloc(iss_fire && sel_add), .alloc_op(op),
        .alloc_vj(pay_vj), .alloc_vk(s2_v), .alloc_qj(pay_qj), .alloc_qk(pay_qk),
        .alloc_lat(iss_lat),
        .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
        .has_free(add_free), .free_tag(add_tag),
        .req(unit_req[0]), .req_tag(unit_rtag[0]), .req_data(unit_rdata[0]),
        .grant(unit_gnt[0])
    );

    tr_station_unit #(.N(N_MUL), .TAG_W(TAG_W), .DATA_W(DATA_W), .LAT_W(LAT_W),
                      .BASE_TAG(MUL_BASE)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .alloc(iss_fire && sel_mul), .alloc_op(op),
        .alloc_vj(pay_vj), .alloc_vk(s2_v), .alloc_qj(pay_qj), .alloc_qk(pay_qk),
        .alloc_lat(iss_lat),
        .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
        .has_free(mul_free), .free_tag(mul_tag),
        .req(unit_req[1]), .req_tag(unit_rtag[1]), .req_data(unit_rdata[1]),
        .grant(unit_gnt[1])
    );

    tr_station_unit #(.N(N_LD), .TAG_W(TAG_W), .DATA_W(DATA_W), .LAT_W(LAT_W),
                      .BASE_TAG(LD_BASE)) u_ld (
        .clk(clk), .rst_n(rst_n),
        .alloc(iss_fire && sel_ld), .alloc_op(op),
        .alloc_vj(pay_vj), .alloc_vk(s2_v), .alloc_qj(pay_qj), .alloc_qk(pay_qk),
        .alloc_lat(iss_lat),
        .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
        .has_free(ld_free), .free_tag(ld_tag),
        .req(unit_req[2]), .req_tag(unit_rtag[2]), .req_data(unit_rdata[2]),
        .grant(unit_gnt[2])
    );

    tr_store_buf #(.N(N_ST), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_st (
        .clk(clk), .rst_n(rst_n),
        .alloc(iss_fire && sel_st), .alloc_addr(iss_imm[ADDR_W-1:0]),
        .alloc_v(s1_v), .alloc_q(s1_q),
        .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
        .has_free(st_free),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
    );

    tr_bus_arb #(.NU(NU), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arb (
        .req(unit_req), .req_tag(unit_rtag), .req_data(unit_rdata),
        .gnt(unit_gnt),
        .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data)
    );

endmodule

// File: rtl/tr_core_chk.sv
// Assertion checker for tr_core, attached by the bind at the end of this file.
module tr_core_chk #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64,
    parameter int NREG   = 16,
    parameter int NU     = 3,
    parameter int NTAG   = 11
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NREG-1:0][TAG_W-1:0]    reg_tag,
    input logic                          iss_writes,
    input logic [$clog2(NREG)-1:0]       iss_dst,
    input logic [TAG_W-1:0]              iss_tag,
    input logic [NU-1:0]                 unit_req,
    input logic [NU-1:0]                 unit_gnt,
    input logic [NU-1:0][TAG_W-1:0]      unit_rtag,
    input logic [NU-1:0][DATA_W-1:0]     unit_rdata,
    input logic                          cdb_valid,
    input logic [TAG_W-1:0]              cdb_tag
);

    localparam int REG_W = $clog2(NREG);

    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_gnt));

    a_r8_bus_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|unit_req) |-> cdb_valid);

    a_r3_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> (cdb_tag != '0) && (cdb_tag <= TAG_W'(NTAG)));

    a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |=> !(cdb_valid && cdb_tag == $past(cdb_tag)));

    for (genvar u = 0; u < NU; u++) begin : g_unit
        a_r8_loser_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_req[u] && !unit_gnt[u]) |=>
                (unit_req[u] && $stable(unit_rtag[u]) && $stable(unit_rdata[u])));
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        a_r7_newest_writer: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_writes && iss_dst == REG_W'(r)) |=> reg_tag[r] == $past(iss_tag));

        a_r4_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && reg_tag[r] != '0 && reg_tag[r] == cdb_tag &&
             !(iss_writes && iss_dst == REG_W'(r))) |=> reg_tag[r] == '0);
    end

endmodule

bind tr_core tr_core_chk #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .NREG(NREG), .NU(NU), .NTAG(NTAG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_tag(reg_tag),
    .iss_writes(iss_writes), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .unit_req(unit_req), .unit_gnt(unit_gnt),
    .unit_rtag(unit_rtag), .unit_rdata(unit_rdata),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag)
);

// File: tb/tb_tr_core.sv
// Directed bench for tr_core: one task per scenario.
module tb_tr_core;

    localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, MUL = 3'd2, LD = 3'd3, ST = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_op = 3'd0;
    logic [3:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [63:0] iss_imm = '0;
    logic        iss_hit = 1'b0;
    logic        iss_ready, cdb_valid, st_valid;
    logic [3:0]  cdb_tag;
    logic [63:0] cdb_data, st_data;
    logic [15:0] st_addr;

    int checks = 0, errors = 0, cyc = 0, last_iss = 0;
    int bus_cnt [16];
    int bus_cyc [16];
    logic [63:0] bus_dat [16];
    int st_cnt = 0, st_cyc = 0;
    logic [15:0] st_a = '0;
    logic [63:0] st_d = '0;

    tr_core dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_imm(iss_imm), .iss_hit(iss_hit), .iss_ready(iss_ready),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log bus and store port activity away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && cdb_valid) begin
            bus_cnt[cdb_tag] = bus_cnt[cdb_tag] + 1;
            bus_cyc[cdb_tag] = cyc;
            bus_dat[cdb_tag] = cdb_data;
        end
        if (rst_n && st_valid) begin
            st_cnt = st_cnt + 1;
            st_cyc = cyc;
            st_a   = st_addr;
            st_d   = st_data;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < 16; i++) begin
            bus_cnt[i] = 0;
            bus_cyc[i] = 0;
            bus_dat[i] = '0;
        end
        st_cnt = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_issue(input logic [2:0] op, input int dst, input int s1,
                            input int s2, input logic [63:0] imm, input logic hit);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_op    = op;
        iss_dst   = 4'(dst);
        iss_src1  = 4'(s1);
        iss_src2  = 4'(s2);
        iss_imm   = imm;
        iss_hit   = hit;
        while (!iss_ready) @(negedge clk);
        @(posedge clk);
        #1;
        last_iss  = cyc;
        iss_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 iss_ready after reset", iss_ready, 1);
        chk("R10 cdb_valid after reset", cdb_valid, 0);
        chk("R10 st_valid after reset", st_valid, 0);
    endtask

    task automatic t_load_latency();
        clear_log();
        do_issue(LD, 1, 0, 0, 64'd5, 1'b1);
        idle(12);
        chk("R5 load hit latency", bus_cyc[6] - last_iss, 2);
        chk("R3 load tag and data", bus_dat[6], 64'd5);
        clear_log();
        do_issue(LD, 2, 0, 0, 64'd7, 1'b0);
        idle(14);
        chk("R5 load miss latency", bus_cyc[6] - last_iss, 9);
        chk("R6 freed load station reused once", bus_cnt[6], 1);
    endtask

    task automatic t_arith();
        clear_log();
        do_issue(ADD, 3, 1, 2, 0, 0);
        idle(10);
        chk("R5 add latency", bus_cyc[1] - last_iss, 3);
        chk("R2 add result", bus_dat[1], 64'd12);
        do_issue(MUL, 4, 1, 2, 0, 0);
        idle(10);
        chk("R5 mul latency", bus_cyc[4] - last_iss, 5);
        chk("R2 mul result", bus_dat[4], 64'd35);
        do_issue(SUB, 5, 1, 2, 0, 0);
        idle(10);
        chk("R2 sub result", bus_dat[1], 64'hFFFF_FFFF_FFFF_FFFE);
        do_issue(ST, 0, 3, 0, 64'h40, 0);
        idle(4);
        chk("R9 ready store cycle", st_cyc - last_iss, 0);
        chk("R9 store addr", st_a, 16'h40);
        chk("R9 store data", st_d, 64'd12);
    endtask

    task automatic t_dependency();
        clear_log();
        do_issue(LD, 6, 0, 0, 64'd3, 1'b0);
        do_issue(MUL, 7, 6, 6, 0, 0);
        do_issue(ST, 0, 6, 0, 64'h10, 0);
        idle(5);
        chk("R5 dependent mul waits", bus_cnt[4], 0);
        chk("R9 store waits for data", st_cnt, 0);
        idle(20);
        chk("R5 mul after operand broadcast", bus_cyc[4] - bus_cyc[6], 6);
        chk("R4 mul captured both operands", bus_dat[4], 64'd9);
        chk("R9 pending store completes after capture", st_cyc - bus_cyc[6], 1);
        chk("R4 store captured data", st_d, 64'd3);
    endtask

    task automatic t_forward();
        clear_log();
        do_issue(LD, 8, 0, 0, 64'd11, 1'b1);
        idle(2);
        do_issue(ADD, 9, 8, 8, 0, 0);
        idle(10);
        chk("R4 issue-cycle forwarding", bus_dat[1], 64'd22);
        chk("R4 forwarded add latency", bus_cyc[1] - last_iss, 3);
        do_issue(ST, 0, 8, 0, 64'h11, 0);
        idle(3);
        chk("R4 register captured broadcast", st_d, 64'd11);
    endtask

    task automatic t_waw();
        clear_log();
        do_issue(LD, 10, 0, 0, 64'd100, 1'b0);
        do_issue(LD, 10, 0, 0, 64'd200, 1'b1);
        idle(15);
        chk("R6 stale writer still broadcasts", bus_dat[6], 64'd100);
        do_issue(ST, 0, 10, 0, 64'h22, 0);
        idle(3);
        chk("R7 newest writer kept", st_d, 64'd200);
    endtask

    task automatic t_war();
        clear_log();
        do_issue(LD, 14, 0, 0, 64'd4, 1'b0);
        do_issue(ADD, 15, 14, 1, 0, 0);
        do_issue(LD, 1, 0, 0, 64'd50, 1'b1);
        idle(20);
        chk("R11 reader keeps old value", bus_dat[1], 64'd9);
        do_issue(ST, 0, 1, 0, 64'h33, 0);
        idle(3);
        chk("R11 later writer landed", st_d, 64'd50);
    endtask

    task automatic t_stall();
        clear_log();
        do_issue(LD, 6, 0, 0, 64'd3, 1'b0);
        do_issue(MUL, 7, 6, 2, 0, 0);
        do_issue(MUL, 11, 6, 2, 0, 0);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_op    = MUL;
        iss_dst   = 4'd12;
        iss_src1  = 4'd2;
        iss_src2  = 4'd2;
        chk("R1 ready low with multipliers full", iss_ready, 0);
        @(negedge clk);
        chk("R1 ready stays low", iss_ready, 0);
        iss_valid = 1'b0;
        idle(25);
        chk("R1 held op not taken (Mult1 once)", bus_cnt[4], 1);
        chk("R1 held op not taken (Mult2 once)", bus_cnt[5], 1);
        chk("R8 Mult1 result", bus_dat[4], 64'd21);
        chk("R8 Mult2 after Mult1", bus_cyc[5] - bus_cyc[4], 1);
        chk("R1 ready after free", iss_ready, 1);
    endtask

    task automatic t_collide();
        clear_log();
        do_issue(MUL, 4, 1, 2, 0, 0);
        begin
            int k = last_iss;
            idle(1);
            do_issue(ADD, 3, 2, 2, 0, 0);
            idle(10);
            chk("R8 add wins collision", bus_cyc[1] - k, 5);
            chk("R8 mul held one cycle", bus_cyc[4] - k, 6);
            chk("R8 held mul data", bus_dat[4], 64'd350);
            chk("R8 add data", bus_dat[1], 64'd14);
        end
    endtask

    initial begin
        clear_log();
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_latency();
        t_arith();
        t_dependency();
        t_forward();
        t_waw();
        t_war();
        t_stall();
        t_collide();
        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule